// File: doc/BRIEF.md
# I2C Bit-Clock and Edge-Timing Unit

This unit produces the clock line of an I2C master and tells the byte sequencer when it may move the data line and when the data line holds a valid bit. The sequencer issues one of four line-level operations at a time: a start condition, one data bit, a stop condition, or a repeated start. Each operation is timed from a set of programmed counts. A prescaler divides the input clock into ticks, and every interval is counted in those ticks, so an interval programmed as N lasts (N+1)·(DIV+1) input clocks. The timing values are packed into three 32-bit words plus one separate data-hold word. There is one set of three words for fast operation and one for high-speed operation, and a mode input picks the set.

Both bus lines come back through a two-flop synchronizer and a programmable glitch filter before the unit looks at them. When the unit releases the clock line, it waits until the filtered line reads high before it starts counting the high period. A target that holds the clock low therefore stretches the period, and the unit flags this for as long as the wait lasts. The unit does not compute the timing values and does not sequence bytes.

Top module: `i2c_scl_timer`

## Requirements
- R1: After a synchronous reset both line drivers are released, `busy`, `stretching`, `drive_strobe`, `sample_strobe` and `sample_bit` are low, and the filtered lines read high.
- R2: A prescaler gives one tick every DIV+1 clocks. DIV sits in bits 23:16 of timing word 3. A counted interval of N lasts exactly (N+1)·(DIV+1) clocks from the edge that enters it.
- R3: A start command is `cmd`=0, accepted with `cmd_go` while idle. It releases both lines. After the start-setup count (word 1 bits 31:24) it pulls SDA low. After a further start-hold count (word 1 bits 23:16) it pulls SCL low and goes idle.
- R4: Commands 1 (bit), 2 (stop) and 3 (repeated start) begin with a low phase that holds SCL low. SDA takes its new value, with a one-cycle `drive_strobe`, after the data-hold count (hold word bits 7:0). SCL is released after max(SCL-low count, hold+data-setup) intervals. The SCL-low count is word 2 bits 15:8 and data setup is word 2 bits 31:24. For a bit, SDA is driven low exactly when `cmd_bit` is 0.
- R5: For a bit, once the filtered SCL reads high, the unit pulses `sample_strobe` for one cycle and sets `sample_bit` to the filtered SDA. It then holds SCL high for the SCL-high count (word 2 bits 7:0) and pulls SCL low again. SDA does not change while SCL is high.
- R6: While SCL is released and the filtered SCL still reads low, `stretching` is high and no interval counter advances. The full high period is counted only after the filtered line goes high.
- R7: Each bus input passes through two synchronizer flops. The filtered value takes a new level only after FILTER+1 consecutive synchronized samples agree, where FILTER is the 3-bit `filter_cycles` input. A pulse shorter than that is not seen.
- R8: A stop drives SDA low in its low phase and then releases SCL. Once SCL reads high it waits the stop-setup count (word 1 bits 15:8), then releases SDA and goes idle.
- R9: A repeated start leaves SDA released in its low phase and then releases SCL. Once SCL reads high it waits the release count (word 3 bits 7:0), then pulls SDA low, waits the start-hold count, pulls SCL low and goes idle.
- R10: With `hs_mode` high, all fields of words 1–3 come from the high-speed set; otherwise they come from the fast set. Both modes use the one hold word.
- R11: `busy` is high from the edge that accepts a command until the operation ends. A `cmd_go` pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | Selects the high-speed timing set |
| fs_word1 | input | 32 | Fast set: start setup, start hold, stop setup |
| fs_word2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_word3 | input | 32 | Fast set: divider, repeated-start release |
| hs_word1 | input | 32 | High-speed set, same layout as word 1 |
| hs_word2 | input | 32 | High-speed set, same layout as word 2 |
| hs_word3 | input | 32 | High-speed set, same layout as word 3 |
| hold_word | input | 32 | Data-hold count in bits 7:0 |
| filter_cycles | input | 3 | Glitch-filter agreement count minus one |
| cmd | input | 2 | 0 start, 1 bit, 2 stop, 3 repeated start |
| cmd_bit | input | 1 | Bit value for a bit command |
| cmd_go | input | 1 | Starts `cmd` when idle |
| scl_in | input | 1 | Clock line as seen on the bus |
| sda_in | input | 1 | Data line as seen on the bus |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |
| drive_strobe | output | 1 | One-cycle pulse when SDA takes a new value |
| sample_strobe | output | 1 | One-cycle pulse when a bit is sampled |
| sample_bit | output | 1 | Last sampled data bit |
| busy | output | 1 | An operation is in progress |
| stretching | output | 1 | Waiting for the released clock line to read high |

## Verification
The hardest case to reach is a clock line held low by a target at the moment the unit releases it. In the same window the data line should carry a pulse shorter than the filter length. The bench models the bus as wired-AND. It watches for the edge where the unit lets SCL go, then holds the modelled target low for a chosen number of cycles. During that hold it forces a single-cycle low on SDA with the filter set to its deepest useful value. A cycle-accurate behavioural model checks that the high period starts only after the filtered line rises and that the sampled bit ignores the pulse.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int FLD_W = 8;
    localparam int CNT_W = FLD_W + 1;

    typedef enum logic [1:0] {
        CMD_START   = 2'd0,
        CMD_BIT     = 2'd1,
        CMD_STOP    = 2'd2,
        CMD_RESTART = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSU,
        ST_SHD,
        ST_LOW,
        ST_REL,
        ST_HIGH,
        ST_PSU,
        ST_RHI
    } phase_e;

    typedef struct packed {
        logic [FLD_W-1:0] sta_su;
        logic [FLD_W-1:0] sta_hd;
        logic [FLD_W-1:0] sto_su;
        logic [FLD_W-1:0] dat_su;
        logic [FLD_W-1:0] scl_lo;
        logic [FLD_W-1:0] scl_hi;
        logic [FLD_W-1:0] div;
        logic [FLD_W-1:0] rel;
    } timing_t;

    // Length of the low phase in intervals: the larger of the low count and
    // the hold-plus-setup window around the SDA change.
    function automatic logic [CNT_W-1:0] low_end(input timing_t t,
                                                 input logic [FLD_W-1:0] hold);
        logic [CNT_W-1:0] win;
        win = {1'b0, hold} + {1'b0, t.dat_su};
        return (win > {1'b0, t.scl_lo}) ? win : {1'b0, t.scl_lo};
    endfunction

endpackage

// File: rtl/i2ct_prescaler.sv
module i2ct_prescaler #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (pre_q == div);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (run) begin
            if (pre_q == div) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R2: every tick outside a phase load moves the interval count by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6: with the counter stopped the interval count holds
    p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/i2ct_filter.sv
module i2ct_filter #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    localparam int HIST_N = 1 << SEL_W;

    logic [1:0]        sync_q;
    logic [HIST_N-1:0] hist_q;
    logic              dout_q;
    logic              agree;

    always_comb begin
        agree = 1'b1;
        for (int i = 0; i < HIST_N; i++) begin
            if ((i <= int'(sel)) && (hist_q[i] != hist_q[0])) agree = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[HIST_N-2:0], sync_q[1]};
            if (agree) dout_q <= hist_q[0];
        end
    end

    assign dout = dout_q;

    // R7: a new filtered level always equals the newest agreed sample
    p_filter_source_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_q) |-> (dout_q == $past(hist_q[0])));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2ct_pkg::*;
#(
    parameter int FLT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_mode,
    input  logic [31:0]      fs_word1,
    input  logic [31:0]      fs_word2,
    input  logic [31:0]      fs_word3,
    input  logic [31:0]      hs_word1,
    input  logic [31:0]      hs_word2,
    input  logic [31:0]      hs_word3,
    input  logic [31:0]      hold_word,
    input  logic [FLT_W-1:0] filter_cycles,
    input  logic [1:0]       cmd,
    input  logic             cmd_bit,
    input  logic             cmd_go,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             drive_strobe,
    output logic             sample_strobe,
    output logic             sample_bit,
    output logic             busy,
    output logic             stretching
);
    localparam int LINES = 2;

    // ---------------- timing set selection ----------------
    logic [31:0]      w1, w2, w3;
    timing_t          tm;
    logic [FLD_W-1:0] hold;
    logic [CNT_W-1:0] lo_end;
    logic             unused_bits;

    always_comb begin
        w1        = hs_mode ? hs_word1 : fs_word1;
        w2        = hs_mode ? hs_word2 : fs_word2;
        w3        = hs_mode ? hs_word3 : fs_word3;
        tm.sta_su = w1[31:24];
        tm.sta_hd = w1[23:16];
        tm.sto_su = w1[15:8];
        tm.dat_su = w2[31:24];
        tm.scl_lo = w2[15:8];
        tm.scl_hi = w2[7:0];
        tm.div    = w3[23:16];
        tm.rel    = w3[7:0];
    end
    assign hold        = hold_word[7:0];
    assign lo_end      = low_end(tm, hold);
    assign unused_bits = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8], hold_word[31:8]};

    // ---------------- bus input filters ----------------
    logic [LINES-1:0] pad_in, pad_flt;
    logic             filt_scl, filt_sda;
    assign pad_in = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_flt
        i2ct_filter #(.SEL_W(FLT_W)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .din  (pad_in[g]),
            .sel  (filter_cycles),
            .dout (pad_flt[g])
        );
    end
    assign filt_scl = pad_flt[0];
    assign filt_sda = pad_flt[1];

    // ---------------- prescaler ----------------
    phase_e           state_q, state_n;
    logic             load, run, tick;
    logic [CNT_W-1:0] cnt;

    assign run = (state_q != ST_IDLE) && (state_q != ST_REL);

    i2ct_prescaler #(.DIV_W(FLD_W), .CNT_W(CNT_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .run     (run),
        .div     (tm.div),
        .tick    (tick),
        .cnt     (cnt)
    );

    function automatic logic at_cnt(input logic t, input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] n);
        return t && (c == n);
    endfunction

    // ---------------- phase sequencer ----------------
    cmd_e op_q, op_n;
    logic bit_q, bit_n;
    logic scl_low_q, scl_low_n, sda_low_q, sda_low_n;
    logic drv_n, smp_n, smp_bit_q, smp_bit_n;
    logic drv_q, smp_q;

    always_comb begin
        state_n   = state_q;
        op_n      = op_q;
        bit_n     = bit_q;
        scl_low_n = scl_low_q;
        sda_low_n = sda_low_q;
        smp_bit_n = smp_bit_q;
        drv_n     = 1'b0;
        smp_n     = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_go) begin
                op_n  = cmd_e'(cmd);
                bit_n = cmd_bit;
                load  = 1'b1;
                if (cmd_e'(cmd) == CMD_START) begin
                    state_n   = ST_SSU;
                    scl_low_n = 1'b0;
                    sda_low_n = 1'b0;
                end else begin
                    state_n   = ST_LOW;
                    scl_low_n = 1'b1;
                end
            end
            ST_SSU: if (at_cnt(tick, cnt, {1'b0, tm.sta_su})) begin
                sda_low_n = 1'b1;
                state_n   = ST_SHD;
                load      = 1'b1;
            end
            ST_SHD: if (at_cnt(tick, cnt, {1'b0, tm.sta_hd})) begin
                scl_low_n = 1'b1;
                state_n   = ST_IDLE;
            end
            ST_LOW: begin
                if (at_cnt(tick, cnt, {1'b0, hold})) begin
                    sda_low_n = (op_q == CMD_BIT) ? !bit_q : (op_q == CMD_STOP);
                    drv_n     = 1'b1;
                end
                if (at_cnt(tick, cnt, lo_end)) begin
                    scl_low_n = 1'b0;
                    state_n   = ST_REL;
                end
            end
            ST_REL: if (filt_scl) begin
                load = 1'b1;
                unique case (op_q)
                    CMD_BIT: begin
                        state_n   = ST_HIGH;
                        smp_n     = 1'b1;
                        smp_bit_n = filt_sda;
                    end
                    CMD_STOP: state_n = ST_PSU;
                    default:  state_n = ST_RHI;
                endcase
            end
            ST_HIGH: if (at_cnt(tick, cnt, {1'b0, tm.scl_hi})) begin
                scl_low_n = 1'b1;
                state_n   = ST_IDLE;
            end
            ST_PSU: if (at_cnt(tick, cnt, {1'b0, tm.sto_su})) begin
                sda_low_n = 1'b0;
                state_n   = ST_IDLE;
            end
            ST_RHI: if (at_cnt(tick, cnt, {1'b0, tm.rel})) begin
                sda_low_n = 1'b1;
                state_n   = ST_SHD;
                load      = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= CMD_START;
            bit_q     <= 1'b0;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            drv_q     <= 1'b0;
            smp_q     <= 1'b0;
            smp_bit_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            op_q      <= op_n;
            bit_q     <= bit_n;
            scl_low_q <= scl_low_n;
            sda_low_q <= sda_low_n;
            drv_q     <= drv_n;
            smp_q     <= smp_n;
            smp_bit_q <= smp_bit_n;
        end
    end

    assign scl_drive_low = scl_low_q;
    assign sda_drive_low = sda_low_q;
    assign drive_strobe  = drv_q;
    assign sample_strobe = smp_q;
    assign sample_bit    = smp_bit_q;
    assign busy          = (state_q != ST_IDLE);
    assign stretching    = (state_q == ST_REL);

    // R4: SDA only moves on a strobe issued from the low phase
    p_drive_in_low_r4: assert property (@(posedge clk) disable iff (rst)
        drive_strobe |-> ($past(state_q) == ST_LOW));

    // R5: a sample is taken only as the released clock is seen high
    p_sample_src_r5: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> (($past(state_q) == ST_REL) && $past(filt_scl)));

    // R5: data is stable for the whole high period
    p_sda_still_high_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_HIGH) && ($past(state_q) == ST_HIGH)) |-> $stable(sda_low_q));

    // R6: the clock stays released and the wait persists while the line reads low
    p_rel_released_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL) |-> !scl_low_q);
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_REL) && !filt_scl) |=> (state_q == ST_REL));

    // R11: a command offered while busy does not replace the running one
    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_go) |=> (op_q == $past(op_q)));

endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_mode = 1'b0;
    logic [31:0] fs_word1, fs_word2, fs_word3, hs_word1, hs_word2, hs_word3, hold_word;
    logic [2:0]  filter_cycles = 3'd2;
    logic [1:0]  cmd = 2'd0;
    logic        cmd_bit = 1'b0, cmd_go = 1'b0;
    logic        tgt_hold = 1'b0, glitch = 1'b0;
    logic        scl_in, sda_in;
    logic        scl_drive_low, sda_drive_low, drive_strobe, sample_strobe, sample_bit;
    logic        busy, stretching;

    always #2.5 clk = ~clk;   // 200 MHz

    assign scl_in = !(scl_drive_low || tgt_hold);
    assign sda_in = !(sda_drive_low || glitch);

    i2c_scl_timer u0 (
        .clk(clk), .rst(rst), .hs_mode(hs_mode),
        .fs_word1(fs_word1), .fs_word2(fs_word2), .fs_word3(fs_word3),
        .hs_word1(hs_word1), .hs_word2(hs_word2), .hs_word3(hs_word3),
        .hold_word(hold_word), .filter_cycles(filter_cycles),
        .cmd(cmd), .cmd_bit(cmd_bit), .cmd_go(cmd_go),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .drive_strobe(drive_strobe), .sample_strobe(sample_strobe),
        .sample_bit(sample_bit), .busy(busy), .stretching(stretching)
    );

    // timing values per set: index 0 fast, 1 high-speed
    int p_div[2]  = '{1, 0};
    int p_su[2]   = '{2, 1};
    int p_hd[2]   = '{3, 1};
    int p_sto[2]  = '{2, 1};
    int p_dsu[2]  = '{1, 2};
    int p_lo[2]   = '{4, 2};
    int p_hi[2]   = '{3, 1};
    int p_rel[2]  = '{2, 1};
    int p_hold    = 1;

    initial begin
        fs_word1  = {p_su[0][7:0], p_hd[0][7:0], p_sto[0][7:0], 8'h5a};
        fs_word2  = {p_dsu[0][7:0], 8'ha5, p_lo[0][7:0], p_hi[0][7:0]};
        fs_word3  = {8'h3c, p_div[0][7:0], 8'hc3, p_rel[0][7:0]};
        hs_word1  = {p_su[1][7:0], p_hd[1][7:0], p_sto[1][7:0], 8'h11};
        hs_word2  = {p_dsu[1][7:0], 8'h22, p_lo[1][7:0], p_hi[1][7:0]};
        hs_word3  = {8'h33, p_div[1][7:0], 8'h44, p_rel[1][7:0]};
        hold_word = {24'hdead00, p_hold[7:0]};
    end

    int checks = 0, failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural reference ----------------
    int  ms = 0, mk = 0, mop = 0;
    bit  mbit = 0, mscl = 0, msda = 0, mdrv = 0, msmp = 0, msbit = 0;
    bit  q_scl[10], q_sda[10];
    bit  mf_scl = 1, mf_sda = 1;

    function automatic int span(input int n, input int h);
        return (n + 1) * (p_div[h] + 1);
    endfunction

    always @(posedge clk) begin
        int h, le;
        bit ok;
        h  = hs_mode ? 1 : 0;
        le = (p_hold + p_dsu[h] > p_lo[h]) ? p_hold + p_dsu[h] : p_lo[h];
        if (rst) begin
            ms = 0; mk = 0; mop = 0; mbit = 0; mscl = 0; msda = 0;
            mdrv = 0; msmp = 0; msbit = 0; mf_scl = 1; mf_sda = 1;
            for (int j = 0; j < 10; j++) begin q_scl[j] = 1; q_sda[j] = 1; end
        end else begin
            mdrv = 0; msmp = 0;
            case (ms)
                0: if (cmd_go) begin
                    mop = cmd; mbit = cmd_bit; mk = 0;
                    if (cmd == 2'd0) begin ms = 1; mscl = 0; msda = 0; end
                    else begin ms = 3; mscl = 1; end
                end
                1: begin mk++; if (mk == span(p_su[h], h)) begin msda = 1; ms = 2; mk = 0; end end
                2: begin mk++; if (mk == span(p_hd[h], h)) begin mscl = 1; ms = 0; end end
                3: begin
                    mk++;
                    if (mk == span(p_hold, h)) begin
                        msda = (mop == 1) ? !mbit : (mop == 2);
                        mdrv = 1;
                    end
                    if (mk == span(le, h)) begin mscl = 0; ms = 4; end
                end
                4: if (mf_scl) begin
                    mk = 0;
                    if (mop == 1) begin ms = 5; msmp = 1; msbit = mf_sda; end
                    else if (mop == 2) ms = 6;
                    else ms = 7;
                end
                5: begin mk++; if (mk == span(p_hi[h], h)) begin mscl = 1; ms = 0; end end
                6: begin mk++; if (mk == span(p_sto[h], h)) begin msda = 0; ms = 0; end end
                7: begin mk++; if (mk == span(p_rel[h], h)) begin msda = 1; ms = 2; mk = 0; end end
                default: ms = 0;
            endcase
            ok = 1;
            for (int j = 0; j <= int'(filter_cycles); j++) if (q_scl[2+j] != q_scl[2]) ok = 0;
            if (ok) mf_scl = q_scl[2];
            ok = 1;
            for (int j = 0; j <= int'(filter_cycles); j++) if (q_sda[2+j] != q_sda[2]) ok = 0;
            if (ok) mf_sda = q_sda[2];
            for (int j = 9; j > 0; j--) begin q_scl[j] = q_scl[j-1]; q_sda[j] = q_sda[j-1]; end
            q_scl[0] = scl_in;
            q_sda[0] = sda_in;
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- per-cycle comparison and event capture ----------------
    int  t_go = 0, t_scl_low = 0, t_scl_rel = 0, t_sda_low = 0, t_sda_rel = 0;
    int  t_smp = 0, t_str_end = 0, n_str = 0;
    bit  p_scl = 0, p_sda = 0, p_str = 0;

    always @(negedge clk) begin
        if (cyc >= 1) begin
            checks++;
            if (scl_drive_low !== mscl) begin failures++; $display("FAIL R2 scl_drive_low actual=%0b expected=%0b t=%0t", scl_drive_low, mscl, $time); end
            if (sda_drive_low !== msda) begin failures++; $display("FAIL R4 sda_drive_low actual=%0b expected=%0b t=%0t", sda_drive_low, msda, $time); end
            if (drive_strobe !== mdrv) begin failures++; $display("FAIL R4 drive_strobe actual=%0b expected=%0b t=%0t", drive_strobe, mdrv, $time); end
            if (sample_strobe !== msmp) begin failures++; $display("FAIL R5 sample_strobe actual=%0b expected=%0b t=%0t", sample_strobe, msmp, $time); end
            if (sample_bit !== msbit) begin failures++; $display("FAIL R7 sample_bit actual=%0b expected=%0b t=%0t", sample_bit, msbit, $time); end
            if (busy !== (ms != 0)) begin failures++; $display("FAIL R11 busy actual=%0b expected=%0b t=%0t", busy, ms != 0, $time); end
            if (stretching !== (ms == 4)) begin failures++; $display("FAIL R6 stretching actual=%0b expected=%0b t=%0t", stretching, ms == 4, $time); end
        end
        if (scl_drive_low && !p_scl) t_scl_low = cyc;
        if (!scl_drive_low && p_scl) t_scl_rel = cyc;
        if (sda_drive_low && !p_sda) t_sda_low = cyc;
        if (!sda_drive_low && p_sda) t_sda_rel = cyc;
        if (sample_strobe) t_smp = cyc;
        if (!stretching && p_str) t_str_end = cyc;
        if (stretching) n_str++;
        p_scl = scl_drive_low; p_sda = sda_drive_low; p_str = stretching;
    end

    task automatic issue(input int c, input bit b);
        @(negedge clk);
        cmd = c[1:0]; cmd_bit = b; cmd_go = 1'b1;
        @(posedge clk); #1;
        t_go = cyc;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin @(negedge clk); guard++; end
        if (guard >= 5000) chk(0, "R11 idle wait", guard, 0);
        @(negedge clk);
    endtask

    task automatic stretch_bit(input bit b, input int hold_cycles, input int glitch_at);
        issue(1, b);
        while (scl_drive_low) @(negedge clk);
        tgt_hold = 1'b1;
        n_str = 0;
        for (int i = 0; i < hold_cycles; i++) begin
            glitch = (i == glitch_at);
            @(negedge clk);
        end
        glitch = 1'b0;
        tgt_hold = 1'b0;
        wait_idle();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5 * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!scl_drive_low && !sda_drive_low && !busy && !stretching && !drive_strobe
            && !sample_strobe && !sample_bit, "R1 reset outputs", {busy, scl_drive_low, sda_drive_low}, 0);

        // R3 start timing (fast set)
        issue(0, 0);
        wait_idle();
        chk(t_sda_low - t_go == span(p_su[0], 0), "R3 start setup", t_sda_low - t_go, span(p_su[0], 0));
        chk(t_scl_low - t_sda_low == span(p_hd[0], 0), "R3 start hold", t_scl_low - t_sda_low, span(p_hd[0], 0));

        // R4/R2 low phase, R5 high phase and sampled value
        issue(1, 1);
        wait_idle();
        chk(t_scl_rel - t_go == span(4, 0), "R4 R2 low phase", t_scl_rel - t_go, span(4, 0));
        chk(t_scl_low - t_smp == span(p_hi[0], 0), "R5 high phase", t_scl_low - t_smp, span(p_hi[0], 0));
        chk(sample_bit == 1'b1, "R5 sample one", sample_bit, 1);

        // R11 go pulse while busy is ignored
        issue(1, 0);
        repeat (3) @(negedge clk);
        cmd = 2'd0; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk(!busy && scl_drive_low && sda_drive_low, "R11 ignored go", busy, 0);
        chk(sample_bit == 1'b0, "R5 sample zero", sample_bit, 0);

        // R8 stop
        issue(2, 0);
        wait_idle();
        chk(!scl_drive_low && !sda_drive_low, "R8 stop lines free", {scl_drive_low, sda_drive_low}, 0);
        chk(t_sda_rel - t_str_end == span(p_sto[0], 0), "R8 stop setup", t_sda_rel - t_str_end, span(p_sto[0], 0));

        // R6 stretched bit
        issue(0, 0);
        wait_idle();
        stretch_bit(1, 25, -1);
        chk(n_str >= 25, "R6 stretch flagged", n_str, 25);
        chk(t_scl_low - t_smp == span(p_hi[0], 0), "R6 full high after stretch", t_scl_low - t_smp, span(p_hi[0], 0));

        // R9 repeated start
        issue(3, 0);
        wait_idle();
        chk(t_sda_low - t_str_end == span(p_rel[0], 0), "R9 release count", t_sda_low - t_str_end, span(p_rel[0], 0));
        chk(t_scl_low - t_sda_low == span(p_hd[0], 0), "R9 start hold", t_scl_low - t_sda_low, span(p_hd[0], 0));

        // R10 high-speed set (hold+setup window dominates the low count)
        hs_mode = 1'b1;
        issue(1, 1);
        wait_idle();
        chk(t_scl_rel - t_go == span(3, 1), "R10 hs low phase", t_scl_rel - t_go, span(3, 1));
        chk(t_scl_low - t_smp == span(p_hi[1], 1), "R10 hs high phase", t_scl_low - t_smp, span(p_hi[1], 1));
        issue(2, 0);
        wait_idle();
        hs_mode = 1'b0;

        // R7 short SDA pulse during a stretch with deep filter
        filter_cycles = 3'd3;
        repeat (12) @(negedge clk);
        issue(0, 0);
        wait_idle();
        stretch_bit(1, 20, 5);
        chk(sample_bit == 1'b1, "R7 glitch rejected", sample_bit, 1);

        // R7 no filtering depth
        filter_cycles = 3'd0;
        repeat (12) @(negedge clk);
        issue(1, 0);
        wait_idle();
        chk(sample_bit == 1'b0, "R7 zero-depth sample", sample_bit, 0);
        issue(2, 0);
        wait_idle();
        chk(!busy && !scl_drive_low && !sda_drive_low, "R8 final stop", busy, 0);

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule